// File: doc/BRIEF.md
# Relocatable Window Address Decoder

The decoder classifies each transaction arriving on a host-facing port by comparing its address and kind (I/O or memory) against a bank of relocatable windows. Every window has a size fixed at build time (a power of two), a kind fixed at build time, a base programmed at run time and an enable bit. A window that matches claims the cycle positively. The decoder then reports a one-hot hit vector and the byte offset of the access inside the window. A subset of I/O windows, the disk-controller command and control spaces, take part only while a native-mode input is set.

A second stage checks an inclusive base/limit range that belongs to a downstream bridge. A cycle that misses every window but falls in that range is claimed positively and sent to the bridge. A cycle that nothing claims is not aborted. It is handed by subtractive routing to one of two default targets, either the slow legacy-peripheral bridge or the downstream bridge, as a mode input selects.

The result is registered and appears one clock after the address strobe. It holds until the next strobe.

Top module: `addr_decoder`

## Requirements
- R1: `dec_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. While `req_valid` stays low, `dec_hit`, `dec_target` and `dec_offset` keep their last values.
- R2: A window claims a cycle only when the cycle's kind matches the window's kind. `req_is_io`=1 means I/O. By default windows 0 to 5 are I/O and windows 6 and 7 are memory.
- R3: Window i matches when the address bits at and above its size exponent equal the same bits of its base. Base bits below the size are ignored. On a window hit, `dec_offset` is the address masked to the window size. The default sizes for windows 0 to 7 are 8, 4, 8, 4, 16, 256, 1024 and 4096 bytes.
- R4: A window whose `win_en` bit is 0 never claims a cycle.
- R5: Windows 0 to 3 match only while `native_mode` is 1.
- R6: When several windows match, only the lowest-numbered one is reported. `dec_hit` has at most one bit set. `dec_target` is 0 (window) exactly when a bit is set.
- R7: A cycle that no window claims, with `br_en`=1 and `br_base` <= address <= `br_limit` (unsigned, both ends included), gives `dec_target`=1, `dec_hit`=0 and `dec_offset`=address-`br_base`. This applies to both kinds.
- R8: A cycle that nothing claims gives `dec_hit`=0 and `dec_offset`=address. `dec_target` is 2 (legacy bridge) when `sub_to_bridge`=0 and 3 (downstream bridge) when it is 1.
- R9: While `rst_n` is low, `dec_valid`, `dec_hit`, `dec_target` and `dec_offset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | ADDR_W | Transaction address |
| req_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| win_base | input | NUM_WIN*ADDR_W | Window bases, window i in slice i |
| win_en | input | NUM_WIN | Per-window enable |
| native_mode | input | 1 | Enables the native-only windows |
| br_base | input | ADDR_W | Downstream bridge range start |
| br_limit | input | ADDR_W | Downstream bridge range end (inclusive) |
| br_en | input | 1 | Bridge range enable |
| sub_to_bridge | input | 1 | Subtractive target select |
| dec_valid | output | 1 | Registered result valid |
| dec_hit | output | NUM_WIN | One-hot claiming window |
| dec_target | output | 2 | 0 window, 1 bridge range, 2 subtractive legacy, 3 subtractive bridge |
| dec_offset | output | ADDR_W | Offset inside the claimed region, or the raw address |

## Verification
Directed vectors probe each window at its first and last byte and one step outside it. The same address is issued as both I/O and memory, which separates a kind check from a pure address check. The disk windows are probed with native mode on and off, and the enable bits are toggled, so that gating shows up as a fall to subtractive routing. Two windows are placed on overlapping ranges to expose the priority order. Hits at the bridge range limits and just past them separate the inclusive compare from an exclusive one. A random phase mixes kinds, modes and enables near every window, and idle cycles between strobes expose any output that fails to hold.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

   typedef enum logic [1:0] {
      RT_WINDOW  = 2'd0,
      RT_BRIDGE  = 2'd1,
      RT_SUB_LEG = 2'd2,
      RT_SUB_BRG = 2'd3
   } route_t;

   localparam int unsigned LOG2_FIELD_W = 5;

endpackage

// File: rtl/addr_dec_window.sv
module addr_dec_window #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SIZE_LOG2   = 3,
   parameter bit          IS_IO       = 1'b1,
   parameter bit          NATIVE_ONLY = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_io,
   input  logic [ADDR_W-1:0] base,
   input  logic              en,
   input  logic              native_mode,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);
   localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} >> (ADDR_W - SIZE_LOG2);

   if (SIZE_LOG2 < 1 || SIZE_LOG2 >= ADDR_W) begin : g_bad_size
      $error("window size exponent out of range");
   end

   logic gate;
   if (NATIVE_ONLY) begin : g_native
      assign gate = native_mode;
   end else begin : g_always
      assign gate = 1'b1;
   end

   logic kind_ok;
   logic addr_ok;
   assign kind_ok = (is_io == IS_IO);
   assign addr_ok = (((addr ^ base) & ~MASK) == '0);
   assign hit     = en & gate & kind_ok & addr_ok;
   assign offset  = addr & MASK;
endmodule

// File: rtl/addr_dec_priority.sv
module addr_dec_priority #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] raw,
   output logic [N-1:0] onehot,
   output logic         any
);
   if (N < 1) begin : g_bad_n
      $error("priority width must be positive");
   end

   always_comb begin
      logic taken;
      taken  = 1'b0;
      onehot = '0;
      for (int i = 0; i < N; i++) begin
         if (raw[i] && !taken) begin
            onehot[i] = 1'b1;
            taken     = 1'b1;
         end
      end
   end

   assign any = |raw;
endmodule

// File: rtl/addr_dec_bridge.sv
module addr_dec_bridge #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic              en,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);
   assign hit    = en && (addr >= lo) && (addr <= hi);
   assign offset = addr - lo;
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
   import addr_dec_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned NUM_WIN = 8,
   parameter logic [NUM_WIN*LOG2_FIELD_W-1:0] WIN_LOG2 =
      {5'd12, 5'd10, 5'd8, 5'd4, 5'd2, 5'd3, 5'd2, 5'd3},
   parameter logic [NUM_WIN-1:0] WIN_IO     = 8'b0011_1111,
   parameter logic [NUM_WIN-1:0] WIN_NATIVE = 8'b0000_1111
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_is_io,
   input  logic [NUM_WIN*ADDR_W-1:0] win_base,
   input  logic [NUM_WIN-1:0]        win_en,
   input  logic                      native_mode,
   input  logic [ADDR_W-1:0]         br_base,
   input  logic [ADDR_W-1:0]         br_limit,
   input  logic                      br_en,
   input  logic                      sub_to_bridge,
   output logic                      dec_valid,
   output logic [NUM_WIN-1:0]        dec_hit,
   output logic [1:0]                dec_target,
   output logic [ADDR_W-1:0]         dec_offset
);
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("address width out of range");
   end
   if (NUM_WIN < 1 || NUM_WIN > 64) begin : g_bad_count
      $error("window count out of range");
   end

   logic [NUM_WIN-1:0] raw_hit;
   logic [ADDR_W-1:0]  win_off [NUM_WIN];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      addr_dec_window #(
         .ADDR_W      (ADDR_W),
         .SIZE_LOG2   (int'(WIN_LOG2[i*LOG2_FIELD_W +: LOG2_FIELD_W])),
         .IS_IO       (WIN_IO[i]),
         .NATIVE_ONLY (WIN_NATIVE[i])
      ) u_win (
         .addr        (req_addr),
         .is_io       (req_is_io),
         .base        (win_base[i*ADDR_W +: ADDR_W]),
         .en          (win_en[i]),
         .native_mode (native_mode),
         .hit         (raw_hit[i]),
         .offset      (win_off[i])
      );
   end

   logic [NUM_WIN-1:0] pick;
   logic               any_win;

   addr_dec_priority #(.N(NUM_WIN)) u_prio (
      .raw    (raw_hit),
      .onehot (pick),
      .any    (any_win)
   );

   logic              br_hit;
   logic [ADDR_W-1:0] br_off;

   addr_dec_bridge #(.ADDR_W(ADDR_W)) u_brg (
      .addr   (req_addr),
      .lo     (br_base),
      .hi     (br_limit),
      .en     (br_en),
      .hit    (br_hit),
      .offset (br_off)
   );

   logic [ADDR_W-1:0] sel_off;
   always_comb begin
      sel_off = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (pick[i]) sel_off = sel_off | win_off[i];
      end
   end

   route_t            nxt_tgt;
   logic [ADDR_W-1:0] nxt_off;
   always_comb begin
      if (any_win) begin
         nxt_tgt = RT_WINDOW;
         nxt_off = sel_off;
      end else if (br_hit) begin
         nxt_tgt = RT_BRIDGE;
         nxt_off = br_off;
      end else begin
         nxt_tgt = sub_to_bridge ? RT_SUB_BRG : RT_SUB_LEG;
         nxt_off = req_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_hit    <= '0;
         dec_target <= RT_WINDOW;
         dec_offset <= '0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) begin
            dec_hit    <= pick;
            dec_target <= nxt_tgt;
            dec_offset <= nxt_off;
         end
      end
   end

   assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dec_valid && $stable(dec_hit) && $stable(dec_target) && $stable(dec_offset)));
   assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_hit));
   assert_hit_vs_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> ((dec_hit != '0) == (dec_target == RT_WINDOW)));
   assert_sub_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_target == RT_SUB_BRG) |-> $past(sub_to_bridge));
   assert_sub_raw_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_target[1]) |-> (dec_offset == $past(req_addr)));

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
      localparam int unsigned LG = int'(WIN_LOG2[i*LOG2_FIELD_W +: LOG2_FIELD_W]);
      localparam logic [ADDR_W-1:0] CMASK = {ADDR_W{1'b1}} >> (ADDR_W - LG);
      assert_kind_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && dec_hit[i]) |-> ($past(req_is_io) == WIN_IO[i]));
      assert_offset_in_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && dec_hit[i]) |-> ((dec_offset & ~CMASK) == '0));
      assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && dec_hit[i]) |-> $past(win_en[i]));
      if (WIN_NATIVE[i]) begin : g_nat
         assert_native_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_valid && dec_hit[i]) |-> $past(native_mode));
      end
   end
endmodule

// File: tb/addr_decoder_bench.sv
module addr_decoder_bench;
   localparam int AW = 32;
   localparam int NW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_is_io = 1'b0;
   logic [NW*AW-1:0] win_base = '0;
   logic [NW-1:0] win_en = '0;
   logic          native_mode = 1'b0;
   logic [AW-1:0] br_base = '0;
   logic [AW-1:0] br_limit = '0;
   logic          br_en = 1'b0;
   logic          sub_to_bridge = 1'b0;
   logic          dec_valid;
   logic [NW-1:0] dec_hit;
   logic [1:0]    dec_target;
   logic [AW-1:0] dec_offset;

   always #5 clk = ~clk;

   addr_decoder u_addr_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_is_io(req_is_io), .win_base(win_base), .win_en(win_en),
      .native_mode(native_mode), .br_base(br_base), .br_limit(br_limit),
      .br_en(br_en), .sub_to_bridge(sub_to_bridge), .dec_valid(dec_valid),
      .dec_hit(dec_hit), .dec_target(dec_target), .dec_offset(dec_offset)
   );

   // Window description from the requirements (R2, R3, R5)
   int unsigned sz_lg [NW] = '{3, 2, 3, 2, 4, 8, 10, 12};
   bit          is_io [NW] = '{1, 1, 1, 1, 1, 1, 0, 0};
   bit          nat   [NW] = '{1, 1, 1, 1, 0, 0, 0, 0};

   int vectors = 0;
   int errors  = 0;
   bit started = 0;
   bit done    = 0;
   string cur_tag = "R9";

   logic          e_valid;
   logic [NW-1:0] e_hit;
   logic [1:0]    e_tgt;
   logic [AW-1:0] e_off;
   string         e_tag;

   function automatic logic [AW-1:0] base_of(int i);
      return win_base[i*AW +: AW];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid <= 1'b0; e_hit <= '0; e_tgt <= 2'd0; e_off <= '0; e_tag <= "R9";
      end else begin
         e_valid <= req_valid;
         e_tag   <= cur_tag;
         if (req_valid) begin
            longint unsigned a;
            int winner;
            a = req_addr;
            winner = -1;
            for (int i = NW - 1; i >= 0; i--) begin
               longint unsigned b;
               b = base_of(i);
               if (win_en[i] && (is_io[i] == req_is_io) && (!nat[i] || native_mode) &&
                   ((a >> sz_lg[i]) == (b >> sz_lg[i])))
                  winner = i;
            end
            if (winner >= 0) begin
               e_hit <= NW'(1) << winner;
               e_tgt <= 2'd0;
               e_off <= AW'(a % (64'd1 << sz_lg[winner]));
            end else if (br_en && a >= br_base && a <= br_limit) begin
               e_hit <= '0; e_tgt <= 2'd1; e_off <= AW'(a - br_base);
            end else begin
               e_hit <= '0; e_tgt <= sub_to_bridge ? 2'd3 : 2'd2; e_off <= AW'(a);
            end
         end
      end
      started <= 1'b1;
   end

   always @(negedge clk) begin
      if (started && !done) begin
         vectors++;
         if (dec_valid !== e_valid || dec_hit !== e_hit || dec_target !== e_tgt ||
             dec_offset !== e_off) begin
            errors++;
            $display("FAIL %s: got v=%0b hit=%b tgt=%0d off=%h, expected v=%0b hit=%b tgt=%0d off=%h",
                     e_tag, dec_valid, dec_hit, dec_target, dec_offset,
                     e_valid, e_hit, e_tgt, e_off);
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic issue(input logic [AW-1:0] a, input logic io, input string tag);
      @(posedge clk); #2;
      req_valid = 1'b1; req_addr = a; req_is_io = io; cur_tag = tag;
   endtask

   task automatic idle(input string tag);
      @(posedge clk); #2;
      req_valid = 1'b0; req_addr = 32'hDEAD_BEEF; cur_tag = tag;
   endtask

   task automatic set_base(int i, logic [AW-1:0] b);
      win_base[i*AW +: AW] = b;
   endtask

   initial begin
      set_base(0, 32'h0000_01F0); set_base(1, 32'h0000_03F4);
      set_base(2, 32'h0000_0170); set_base(3, 32'h0000_0374);
      set_base(4, 32'h0000_C000); set_base(5, 32'h0000_D000);
      set_base(6, 32'hFED0_0000); set_base(7, 32'hFEB0_0000);
      win_en = '1;
      br_base = 32'hE000_0000; br_limit = 32'hE0FF_FFFF; br_en = 1'b1;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R3: first/last byte, outside, unaligned base bits ignored
      issue(32'h0000_D0A5, 1'b1, "R3");
      issue(32'h0000_D0FF, 1'b1, "R3");
      issue(32'h0000_D100, 1'b1, "R3");
      issue(32'hFEB0_0FFF, 1'b0, "R3");
      set_base(5, 32'h0000_D0C3);
      issue(32'h0000_D011, 1'b1, "R3");
      set_base(5, 32'h0000_D000);
      // R1: idle cycles hold outputs
      idle("R1"); idle("R1");
      issue(32'h0000_C00F, 1'b1, "R1");
      idle("R1");
      // R2: kind mismatch
      issue(32'h0000_D0A5, 1'b0, "R2");
      issue(32'hFED0_03FC, 1'b0, "R2");
      issue(32'hFED0_03FC, 1'b1, "R2");
      // R5: native windows
      native_mode = 1'b0;
      issue(32'h0000_01F3, 1'b1, "R5");
      issue(32'h0000_0376, 1'b1, "R5");
      native_mode = 1'b1;
      issue(32'h0000_01F3, 1'b1, "R5");
      issue(32'h0000_0376, 1'b1, "R5");
      issue(32'h0000_03F8, 1'b1, "R5");
      // R4: enables
      win_en[5] = 1'b0;
      issue(32'h0000_D0A5, 1'b1, "R4");
      win_en = '1;
      issue(32'h0000_D0A5, 1'b1, "R4");
      // R6: overlap, lowest wins
      set_base(4, 32'h0000_D000);
      issue(32'h0000_D005, 1'b1, "R6");
      issue(32'h0000_D035, 1'b1, "R6");
      set_base(4, 32'h0000_C000);
      // R7: bridge range limits
      issue(32'hE000_1234, 1'b0, "R7");
      issue(32'hE000_0000, 1'b1, "R7");
      issue(32'hE0FF_FFFF, 1'b0, "R7");
      issue(32'hE100_0000, 1'b0, "R7");
      issue(32'hDFFF_FFFF, 1'b0, "R7");
      // R8: subtractive target select
      sub_to_bridge = 1'b0;
      issue(32'h1234_5678, 1'b0, "R8");
      sub_to_bridge = 1'b1;
      issue(32'h1234_5678, 1'b0, "R8");
      br_en = 1'b0;
      issue(32'hE000_0010, 1'b0, "R8");
      br_en = 1'b1;
      // random mix near every window
      for (int k = 0; k < 400; k++) begin
         int w;
         logic [AW-1:0] a;
         w = $urandom_range(0, NW - 1);
         a = base_of(w) + AW'($urandom_range(0, (1 << sz_lg[w]) + 8)) - AW'(4);
         native_mode   = 1'($urandom);
         sub_to_bridge = 1'($urandom);
         win_en        = ($urandom_range(0, 3) == 0) ? NW'($urandom) : '1;
         if ($urandom_range(0, 4) == 0) idle("R1");
         else issue(a, 1'($urandom), "R6");
      end
      win_en = '1;
      idle("R1");
      // R9: reset mid-run
      @(posedge clk); #2;
      rst_n = 1'b0; cur_tag = "R9";
      @(posedge clk); #2;
      rst_n = 1'b1;
      idle("R9");
      idle("R9");
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule